// File: doc/BRIEF.md
# Double-Data-Rate Write Capture Assembler

This block is the write-path receiver of a double-data-rate memory device. The controller drives a data strobe that is centred in the data eye. On every rising strobe edge the block latches one n-bit data beat together with its per-byte mask bits. On the falling edge that follows, it latches a second beat. It then joins the two beats into one 2n-bit prefetch word and builds a matching 2n-bit write-enable vector.

Each word is written into a two-entry holding buffer, clocked by the strobe, and read out in the core clock domain. In the core domain the block counts pairs against the programmed burst length and marks the word that ends each burst. If the strobe parks after an odd number of edges, the unmatched half-word is discarded and an error pulse is raised.

Top module: `ddrw_capture_top`

## Requirements
- R1: While reset is asserted and after it is released with the strobe idle, `word_vld_o`, `burst_done_o` and `err_o` are low.
- R2: The beat sampled on a rising strobe edge fills `word_o[DW-1:0]`. The beat sampled on the following falling edge fills `word_o[2*DW-1:DW]`.
- R3: Mask bit k of `dm_i` covers data byte k, which is bits [8k+7:8k] of the beat. When the mask bit is sampled high, the 8 matching bits of `wen_o` are 0, so that byte is not written. When it is sampled low, they are 1. The first beat's mask maps to `wen_o[DW-1:0]` and the second beat's mask to `wen_o[2*DW-1:DW]`.
- R4: `word_vld_o` is high for exactly one core cycle for each completed rising/falling pair.
- R5: `blen_i` selects the burst length: 1 means 2 beats, 2 means 4 beats, 3 means 8 beats, and 0 is treated as 2 beats. `burst_done_o` is high together with the `word_vld_o` of the last pair of each burst.
- R6: Bursts sent back to back are counted separately: the pair count restarts after every `burst_done_o`.
- R7: Words leave in the order in which they were captured, with none lost, as long as the core clock drains the buffer faster than pairs arrive.
- R8: If the strobe has had a rising edge without its falling edge for TIMEOUT core cycles, `err_o` pulses for one cycle and the pair count is cleared. The falling edge that later returns the strobe low produces no word, and the next burst assembles normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| dqs_i | input | 1 | Write data strobe from the controller |
| dq_i | input | DW | Write data beat |
| dm_i | input | DW/8 | Per-byte mask, high = do not write |
| blen_i | input | 2 | Burst length code |
| word_o | output | 2*DW | Assembled prefetch word |
| wen_o | output | 2*DW | Per-bit write enable of the word |
| word_vld_o | output | 1 | One-cycle pulse per assembled word |
| burst_done_o | output | 1 | Marks the last word of a burst |
| err_o | output | 1 | One-cycle pulse on an unmatched strobe edge |

## Verification
A word reaches `word_o` in the core domain between three and five core cycles after its falling strobe edge. The delay comes from two synchroniser stages and one output register, plus the unknown phase between strobe and clock. The error pulse follows the last strobe edge by TIMEOUT cycles plus the synchroniser delay. For this reason the bench does not sample at one fixed cycle. A monitor records every pulse on the falling core-clock edge, and each scenario task then waits a settle window much longer than the worst-case delay before it compares the recorded words, enables, done flags and error count with values computed from the requirements.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;
  // pairs per burst for a burst length code
  function automatic logic [3:0] pairs_for(input logic [1:0] code);
    case (code)
      2'd2:    return 4'd2;
      2'd3:    return 4'd4;
      default: return 4'd1;
    endcase
  endfunction
endpackage

// File: rtl/ddrw_sync.sv
module ddrw_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s0_q, s1_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= '0;
      s1_q <= '0;
    end else begin
      s0_q <= d_i;
      s1_q <= s0_q;
    end
  end
  assign q_o = s1_q;
endmodule

// File: rtl/ddrw_edge_capture.sv
module ddrw_edge_capture #(
  parameter int DW = 16,
  localparam int NB = DW / 8,
  localparam int EW = 2 * DW + 2 * NB
) (
  input  logic                 dqs_i,
  input  logic                 rst_ni,
  input  logic [DW-1:0]        dq_i,
  input  logic [NB-1:0]        dm_i,
  input  logic                 drop_req_i,
  output logic                 rise_tgl_o,
  output logic                 fall_tgl_o,
  output logic [1:0]           wgray_o,
  output logic [1:0][EW-1:0]   mem_o
);
  logic [DW-1:0] lo_dq_q;
  logic [NB-1:0] lo_dm_q;
  logic          rise_tgl_q, fall_tgl_q, drop_ack_q;
  logic [1:0]    wbin_q, wgray_q, wbin_nxt;
  logic          pend, keep;

  assign pend     = rise_tgl_q != fall_tgl_q;
  assign keep     = pend && (drop_req_i == drop_ack_q);
  assign wbin_nxt = wbin_q + 2'd1;

  always_ff @(posedge dqs_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_dq_q    <= '0;
      lo_dm_q    <= '0;
      rise_tgl_q <= 1'b0;
    end else begin
      lo_dq_q    <= dq_i;
      lo_dm_q    <= dm_i;
      rise_tgl_q <= ~rise_tgl_q;
    end
  end

  always_ff @(negedge dqs_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_tgl_q <= 1'b0;
      drop_ack_q <= 1'b0;
      wbin_q     <= '0;
      wgray_q    <= '0;
    end else if (pend) begin
      fall_tgl_q <= rise_tgl_q;
      if (!keep) begin
        drop_ack_q <= drop_req_i; // orphan edge after an odd stop
      end else begin
        wbin_q  <= wbin_nxt;
        wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
      end
    end
  end

  // holding buffer, strobe is the write clock
  always_ff @(negedge dqs_i) begin
    if (keep) mem_o[wbin_q[0]] <= {dm_i, lo_dm_q, dq_i, lo_dq_q};
  end

  assign rise_tgl_o = rise_tgl_q;
  assign fall_tgl_o = fall_tgl_q;
  assign wgray_o    = wgray_q;

  // every rising edge opens a fresh pair
  assert_rise_starts_pair_R2: assert property (@(posedge dqs_i) disable iff (!rst_ni)
    rise_tgl_q == fall_tgl_q);
endmodule

// File: rtl/ddrw_core_reader.sv
module ddrw_core_reader
  import ddrw_pkg::*;
#(
  parameter int DW      = 16,
  parameter int TIMEOUT = 16,
  localparam int NB = DW / 8,
  localparam int EW = 2 * DW + 2 * NB,
  localparam int TW = $clog2(TIMEOUT + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         blen_i,
  input  logic [1:0][EW-1:0] mem_i,
  input  logic               rise_s_i,
  input  logic               fall_s_i,
  input  logic [1:0]         wgray_s_i,
  output logic [2*DW-1:0]    word_o,
  output logic [2*DW-1:0]    wen_o,
  output logic               word_vld_o,
  output logic               burst_done_o,
  output logic               err_o,
  output logic               drop_req_o
);
  logic [1:0]      wbin_s, rbin_q, occ;
  logic            pop, mism, err_set, last;
  logic [EW-1:0]   ent;
  logic [2*DW-1:0] wen_d;
  logic [3:0]      pair_cnt_q;
  logic [TW-1:0]   idle_q;

  assign wbin_s  = {wgray_s_i[1], ^wgray_s_i};
  assign occ     = wbin_s - rbin_q;
  assign pop     = wbin_s != rbin_q;
  assign ent     = mem_i[rbin_q[0]];
  assign mism    = rise_s_i ^ fall_s_i;
  assign err_set = mism && (idle_q == TW'(TIMEOUT - 1));
  assign last    = (pair_cnt_q + 4'd1) >= pairs_for(blen_i);

  always_comb begin
    for (int k = 0; k < NB; k++) begin
      wen_d[8*k +: 8]      = {8{~ent[2*DW + k]}};
      wen_d[DW + 8*k +: 8] = {8{~ent[2*DW + NB + k]}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q       <= '0;
      word_o       <= '0;
      wen_o        <= '0;
      word_vld_o   <= 1'b0;
      burst_done_o <= 1'b0;
      pair_cnt_q   <= '0;
    end else begin
      word_vld_o   <= pop;
      burst_done_o <= pop && last;
      if (pop) begin
        rbin_q <= rbin_q + 2'd1;
        word_o <= ent[2*DW-1:0];
        wen_o  <= wen_d;
      end
      if (err_set)   pair_cnt_q <= '0;
      else if (pop)  pair_cnt_q <= last ? 4'd0 : pair_cnt_q + 4'd1;
    end
  end

  // unmatched rising edge watchdog
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q     <= '0;
      err_o      <= 1'b0;
      drop_req_o <= 1'b0;
    end else begin
      err_o <= err_set;
      if (!mism)                         idle_q <= '0;
      else if (idle_q != TW'(TIMEOUT))   idle_q <= idle_q + 1'b1;
      if (err_set) drop_req_o <= ~drop_req_o;
    end
  end

  assert_done_with_word_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_done_o |-> word_vld_o);
  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= 2'd2);
  assert_err_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
endmodule

// File: rtl/ddrw_capture_top.sv
module ddrw_capture_top #(
  parameter int DW      = 16,
  parameter int TIMEOUT = 16,
  localparam int NB = DW / 8,
  localparam int EW = 2 * DW + 2 * NB
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dqs_i,
  input  logic [DW-1:0]   dq_i,
  input  logic [NB-1:0]   dm_i,
  input  logic [1:0]      blen_i,
  output logic [2*DW-1:0] word_o,
  output logic [2*DW-1:0] wen_o,
  output logic            word_vld_o,
  output logic            burst_done_o,
  output logic            err_o
);
  logic               rise_tgl, fall_tgl, drop_req;
  logic [1:0]         wgray;
  logic [1:0][EW-1:0] mem;
  logic [3:0]         sync_q;

  ddrw_edge_capture #(.DW(DW)) u_cap (
    .dqs_i      (dqs_i),
    .rst_ni     (rst_ni),
    .dq_i       (dq_i),
    .dm_i       (dm_i),
    .drop_req_i (drop_req),
    .rise_tgl_o (rise_tgl),
    .fall_tgl_o (fall_tgl),
    .wgray_o    (wgray),
    .mem_o      (mem)
  );

  ddrw_sync #(.W(4)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({rise_tgl, fall_tgl, wgray}),
    .q_o    (sync_q)
  );

  ddrw_core_reader #(.DW(DW), .TIMEOUT(TIMEOUT)) u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .blen_i       (blen_i),
    .mem_i        (mem),
    .rise_s_i     (sync_q[3]),
    .fall_s_i     (sync_q[2]),
    .wgray_s_i    (sync_q[1:0]),
    .word_o       (word_o),
    .wen_o        (wen_o),
    .word_vld_o   (word_vld_o),
    .burst_done_o (burst_done_o),
    .err_o        (err_o),
    .drop_req_o   (drop_req)
  );
endmodule

// File: tb/tb_ddrw_capture_top.sv
module tb_ddrw_capture_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NB = DW / 8;

  logic clk = 0, rst_n = 0, dqs = 0;
  logic [DW-1:0] dq = '0;
  logic [NB-1:0] dm = '0;
  logic [1:0] blen = 2'd1;
  logic [2*DW-1:0] word, wen;
  logic vld, done, err;

  int checks = 0, fails = 0;
  int n_got = 0, n_done = 0, n_err = 0;
  logic [2*DW-1:0] got_w [64];
  logic [2*DW-1:0] got_e [64];
  logic            got_d [64];
  logic [2*DW-1:0] exp_w [64];
  logic [2*DW-1:0] exp_e [64];

  ddrw_capture_top #(.DW(DW), .TIMEOUT(16)) dut (
    .clk_i(clk), .rst_ni(rst_n), .dqs_i(dqs), .dq_i(dq), .dm_i(dm),
    .blen_i(blen), .word_o(word), .wen_o(wen), .word_vld_o(vld),
    .burst_done_o(done), .err_o(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (vld && n_got < 64) begin
        got_w[n_got] = word;
        got_e[n_got] = wen;
        got_d[n_got] = done;
        n_got++;
      end
      if (done) n_done++;
      if (err) n_err++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*DW-1:0] en_of(input logic [NB-1:0] mlo, input logic [NB-1:0] mhi);
    logic [2*DW-1:0] e;
    for (int k = 0; k < NB; k++) begin
      e[8*k +: 8]      = {8{~mlo[k]}};
      e[DW + 8*k +: 8] = {8{~mhi[k]}};
    end
    return e;
  endfunction

  task automatic clear_mon();
    @(posedge clk); #1;
    n_got = 0; n_done = 0; n_err = 0;
  endtask

  task automatic half(input logic [DW-1:0] d, input logic [NB-1:0] m, input logic lvl);
    dq = d; dm = m;
    #4 dqs = lvl;
    #4;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    check(vld == 0 && done == 0 && err == 0, "R1 in reset", {vld, done, err}, 0);
    #(CLK_PERIOD*3) rst_n = 1;
    settle(8);
    check(n_got == 0 && n_done == 0 && n_err == 0, "R1 idle after reset", n_got + n_done + n_err, 0);
    check(vld == 0 && done == 0 && err == 0, "R1 outputs low", {vld, done, err}, 0);
  endtask

  // npairs pairs, masks rotate with seed
  task automatic t_burst(input logic [1:0] code, input int npairs, input logic [15:0] seed, input string tag);
    int need;
    need = (code == 2) ? 2 : (code == 3) ? 4 : 1;
    clear_mon();
    blen = code;
    for (int i = 0; i < npairs; i++) begin
      logic [DW-1:0] lo, hi;
      logic [NB-1:0] mlo, mhi;
      lo = seed + 16'(i * 16'h1357);
      hi = ~seed ^ 16'(i * 16'h0f21);
      mlo = NB'(i + seed[1:0]);
      mhi = NB'(i * 3 + seed[3:2]);
      exp_w[i] = {hi, lo};
      exp_e[i] = en_of(mlo, mhi);
      half(lo, mlo, 1'b1);
      half(hi, mhi, 1'b0);
    end
    dm = '0;
    settle(12);
    check(n_got == npairs, {tag, " R4 word count"}, n_got, npairs);
    for (int i = 0; i < npairs && i < n_got; i++) begin
      check(got_w[i] == exp_w[i], {tag, " R2 R7 word order"}, got_w[i], exp_w[i]);
      check(got_e[i] == exp_e[i], {tag, " R3 enables"}, got_e[i], exp_e[i]);
      check(got_d[i] == (((i + 1) % need) == 0), {tag, " R5 R6 done position"}, got_d[i], ((i + 1) % need) == 0);
    end
    check(n_done == npairs / need, {tag, " R6 done count"}, n_done, npairs / need);
    check(n_err == 0, {tag, " R8 no error"}, n_err, 0);
  endtask

  task automatic t_odd();
    clear_mon();
    blen = 2'd2;
    half(16'h1111, 2'b00, 1'b1);
    half(16'h2222, 2'b00, 1'b0);
    half(16'h3333, 2'b11, 1'b1);
    settle(40);
    check(n_err == 1, "R8 error pulse", n_err, 1);
    check(n_got == 1 && n_done == 0, "R8 partial not emitted", n_got, 1);
    dqs = 0;
    settle(10);
    check(n_got == 1, "R8 orphan edge dropped", n_got, 1);
    half(16'h4444, 2'b01, 1'b1);
    half(16'h5555, 2'b10, 1'b0);
    half(16'h6666, 2'b00, 1'b1);
    half(16'h7777, 2'b00, 1'b0);
    settle(12);
    check(n_got == 3, "R8 recovery count", n_got, 3);
    check(got_w[1] == 32'h5555_4444, "R8 recovery word", got_w[1], 32'h5555_4444);
    check(got_e[1] == en_of(2'b01, 2'b10), "R3 recovery enables", got_e[1], en_of(2'b01, 2'b10));
    check(got_w[2] == 32'h7777_6666 && got_d[2] && !got_d[1], "R8 count cleared", {got_d[1], got_d[2]}, 2'b01);
    check(n_done == 1 && n_err == 1, "R8 single error", {n_done, n_err}, {32'd1, 32'd1});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_burst(2'd1, 1, 16'hA5C3, "bl2");
    t_burst(2'd2, 2, 16'h0F0F, "bl4");
    t_burst(2'd3, 4, 16'h1234, "bl8");
    t_burst(2'd0, 1, 16'h8001, "code0");
    t_burst(2'd2, 4, 16'hBEEF, "b2b bl4");
    t_burst(2'd1, 3, 16'h7E57, "b2b bl2");
    t_odd();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule